// File: doc/BRIEF.md
# Secure-Banked Interrupt Priority Mask

This block is one slice of a per-core interrupt CPU interface. It holds two 8-bit priority values: the priority mask, which sets the threshold an interrupt must beat, and the running priority of the interrupt now being handled. It compares the best pending interrupt against both values and drives a registered interrupt request.

Secure and non-secure software see these values differently. When the top exception level is implemented, the access is non-secure, and FIQ routing to the top level is enabled, the block applies a shifted view. In that view non-secure software sees only the upper half of the priority range, scaled up by one bit. It also cannot touch a mask that secure software has parked in the secure range (bit 7 clear). In every other case reads and writes pass through unchanged.

Register access uses a read strobe and a write strobe, a one-bit register select, and a flag that marks the access as secure. Read data is registered. The running priority is loaded through the same port by direct-view writes, which stand in for the acknowledge flow that lies outside this slice.

Top module: `prio_mask_slice`

## Requirements
- R1: After synchronous reset the mask is 0x00, the running priority is 0xFF, read data is 0x00 and the request output is low.
- R2: When the shifted view is not in force, a write stores the data unchanged into the selected register (select 0 = mask, 1 = running priority). A read returns the stored value in read data on the clock edge after the strobe. Read data holds its value when no read is strobed.
- R3: The shifted view is in force exactly when the top level is present, the access is non-secure, and FIQ routing is enabled. In that view a mask read returns (mask << 1) truncated to 8 bits when mask bit 7 is 1, and returns 0x00 when bit 7 is 0. For example, a stored 0xFF reads as 0xFE and a stored 0x7F reads as 0x00.
- R4: A shifted-view write to the mask leaves the mask unchanged when the stored mask has bit 7 equal to 0.
- R5: A shifted-view write to the mask, with stored mask bit 7 equal to 1, stores (data >> 1) with bit 7 forced to 1.
- R6: A shifted-view read of the running priority uses the same translation as R3.
- R7: A shifted-view write to the running priority leaves it unchanged.
- R8: One clock after its inputs settle, the request output is high exactly when an interrupt is pending and its priority value is strictly below both the mask and the running priority.
- R9: With the mask at 0x7F, a pending interrupt whose priority has bit 7 set does not raise the request.
- R10: A write takes effect at the clock edge where its strobe is sampled. A read strobed in the same cycle returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 running priority |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| acc_secure | input | 1 | Access is from secure software |
| top_el_present | input | 1 | Highest exception level is implemented |
| fiq_route_top | input | 1 | FIQ routing to highest level is enabled |
| pend_valid | input | 1 | A pending interrupt exists |
| pend_prio | input | 8 | Priority of best pending interrupt |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach from the ports is a non-secure write that lands on a mask already sitting in a given priority range. The mask can only be placed there by an earlier access with a different view. Each vector therefore first seeds the mask with a secure write, alternating between 0x40 (secure range) and 0xC0 (non-secure range). It then applies one of the 256 data values under each of the eight secure/present/routing combinations. Finally it reads back both the raw value, through a secure read, and the translated value, through a shifted read.

// File: rtl/prio_mask_pkg.sv
package prio_mask_pkg;
  localparam int PRIO_W = 8;
  localparam int NREG   = 2;
  localparam int SEL_W  = 1;
  typedef enum logic [SEL_W-1:0] {
    SEL_MASK    = 1'b0,
    SEL_RUNNING = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/prio_view_xlat.sv
// Translation between stored priority and the shifted half-range view.
module prio_view_xlat #(
  parameter int W = 8
) (
  input  logic [W-1:0] stored,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_view,
  output logic         wr_ok,
  output logic [W-1:0] wr_view
);
  always_comb begin
    rd_view = stored[W-1] ? {stored[W-2:0], 1'b0} : '0;
    wr_ok   = stored[W-1];
    wr_view = {1'b1, wr_data[W-1:1]};
  end
endmodule

// File: rtl/prio_reg_bank.sv
module prio_reg_bank
  import prio_mask_pkg::*;
#(
  parameter int W     = PRIO_W,
  parameter int N     = NREG,
  parameter int SW    = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          wr,
  input  logic [SW-1:0] sel,
  input  logic [W-1:0]  wdata,
  input  logic          shifted,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  run_q
);
  localparam int MASK_IDX = 0;
  localparam int RUN_IDX  = 1;

  logic [W-1:0] reg_q   [N];
  logic [W-1:0] rd_view [N];
  logic [W-1:0] wr_view [N];
  logic         wr_ok   [N];
  logic [W-1:0] rdata_q;

  for (genvar g = 0; g < N; g++) begin : g_xlat
    prio_view_xlat #(.W(W)) u_xlat (
      .stored (reg_q[g]),
      .wr_data(wdata),
      .rd_view(rd_view[g]),
      .wr_ok  (wr_ok[g]),
      .wr_view(wr_view[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        reg_q[i] <= (i == RUN_IDX) ? {W{1'b1}} : '0;
    end else if (wr) begin
      for (int i = 0; i < N; i++) begin
        if (sel == SW'(i)) begin
          if (!shifted)
            reg_q[i] <= wdata;
          else if (i == MASK_IDX && wr_ok[i])
            reg_q[i] <= wr_view[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd)
      rdata_q <= shifted ? rd_view[sel] : reg_q[sel];
  end

  assign rdata  = rdata_q;
  assign mask_q = reg_q[MASK_IDX];
  assign run_q  = reg_q[RUN_IDX];

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && run_q == {W{1'b1}} && rdata == '0)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R2
  AST_NS_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr && shifted && sel == SW'(MASK_IDX) && !mask_q[W-1]) |=> $stable(mask_q)); // R4
  AST_NS_WR_TOPBIT: assert property (@(posedge clk) disable iff (rst)
    (wr && shifted && sel == SW'(MASK_IDX) && mask_q[W-1]) |=> mask_q[W-1]); // R5
  AST_RUN_NS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr && shifted && sel == SW'(RUN_IDX)) |=> $stable(run_q)); // R7
endmodule

// File: rtl/prio_irq_gate.sv
module prio_irq_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pend_valid,
  input  logic [W-1:0] pend_prio,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] running,
  output logic         irq
);
  logic beats_mask, beats_run, irq_q;

  always_comb begin
    beats_mask = pend_prio < mask;
    beats_run  = pend_prio < running;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend_valid && beats_mask && beats_run;
  end

  assign irq = irq_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!pend_valid || pend_prio >= mask || pend_prio >= running) |=> !irq); // R8
  AST_NS_PRIO_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (mask == W'(8'h7F) && pend_prio[W-1]) |=> !irq); // R9
endmodule

// File: rtl/prio_mask_slice.sv
module prio_mask_slice
  import prio_mask_pkg::*;
#(
  parameter int W = PRIO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         acc_secure,
  input  logic         top_el_present,
  input  logic         fiq_route_top,
  input  logic         pend_valid,
  input  logic [W-1:0] pend_prio,
  output logic         irq_req
);
  logic         shifted;
  logic [W-1:0] mask_q, run_q;

  assign shifted = top_el_present && !acc_secure && fiq_route_top;

  prio_reg_bank #(.W(W), .N(NREG), .SW(SEL_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .wr    (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .shifted(shifted),
    .rdata (reg_rdata),
    .mask_q(mask_q),
    .run_q (run_q)
  );

  prio_irq_gate #(.W(W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .pend_valid(pend_valid),
    .pend_prio (pend_prio),
    .mask      (mask_q),
    .running   (run_q),
    .irq       (irq_req)
  );

  AST_SECURE_PASS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !shifted && reg_sel == 1'b0) |=> mask_q == $past(reg_wdata)); // R2
endmodule

// File: tb/prio_mask_slice_tb.sv
module prio_mask_slice_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_rd = 0, reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       acc_secure = 1, top_el_present = 0, fiq_route_top = 0;
  logic       pend_valid = 0;
  logic [7:0] pend_prio = 0;
  logic       irq_req;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  prio_mask_slice u_dut (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_secure(acc_secure),
    .top_el_present(top_el_present), .fiq_route_top(fiq_route_top),
    .pend_valid(pend_valid), .pend_prio(pend_prio), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] view(input logic [7:0] v);
    return v[7] ? {v[6:0], 1'b0} : 8'h00;
  endfunction

  task automatic set_ctx(input bit sec, input bit pres, input bit route);
    @(negedge clk);
    acc_secure = sec; top_el_present = pres; fiq_route_top = route;
  endtask

  task automatic wr_reg(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input bit sel, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq_req}, 8'h00);
    set_ctx(1, 0, 0);
    rd_reg(0, d); chk("R1 mask", d, 8'h00);
    rd_reg(1, d); chk("R1 running", d, 8'hFF);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    set_ctx(1, 1, 1);
    wr_reg(0, 8'h5A); rd_reg(0, d); chk("R2 mask", d, 8'h5A);
    wr_reg(1, 8'h33); rd_reg(1, d); chk("R2 running", d, 8'h33);
    @(negedge clk); @(negedge clk);
    chk("R2 hold", reg_rdata, 8'h33);
    set_ctx(0, 0, 1);
    wr_reg(1, 8'hC4); rd_reg(1, d); chk("R2 ns no-top", d, 8'hC4);
    wr_reg(1, 8'hFF);
  endtask

  task automatic t_examples();
    logic [7:0] d;
    set_ctx(1, 1, 1); wr_reg(0, 8'hFF);
    set_ctx(0, 1, 1); rd_reg(0, d); chk("R3 0xFF view", d, 8'hFE);
    set_ctx(1, 1, 1); wr_reg(0, 8'h7F);
    set_ctx(0, 1, 1); rd_reg(0, d); chk("R3 0x7F view", d, 8'h00);
  endtask

  task automatic t_running_view();
    logic [7:0] d;
    set_ctx(1, 1, 1); wr_reg(1, 8'hA5);
    set_ctx(0, 1, 1); rd_reg(1, d); chk("R6 run view hi", d, 8'h4A);
    wr_reg(1, 8'h00);
    set_ctx(1, 1, 1); rd_reg(1, d); chk("R7 run ns write ignored", d, 8'hA5);
    wr_reg(1, 8'h30);
    set_ctx(0, 1, 1); rd_reg(1, d); chk("R6 run view lo", d, 8'h00);
    set_ctx(1, 1, 1); wr_reg(1, 8'hFF);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    set_ctx(1, 0, 0); wr_reg(0, 8'h11);
    @(negedge clk);
    reg_wr = 1; reg_rd = 1; reg_sel = 0; reg_wdata = 8'h22;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    chk("R10 read old", reg_rdata, 8'h11);
    rd_reg(0, d); chk("R10 write landed", d, 8'h22);
  endtask

  task automatic t_exhaustive();
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 2; b++) begin
        for (int v = 0; v < 256; v++) begin
          bit sec = c[0];
          bit pres = c[1];
          bit route = c[2];
          bit sh = pres && !sec && route;
          logic [7:0] base = b[0] ? 8'hC0 : 8'h40;
          logic [7:0] exp_m;
          logic [7:0] d;
          if (!sh)          exp_m = v[7:0];
          else if (base[7]) exp_m = {1'b1, v[7:1]};
          else              exp_m = base;
          set_ctx(1, pres, route); wr_reg(0, base);
          set_ctx(sec, pres, route); wr_reg(0, v[7:0]);
          if (sh) begin
            rd_reg(0, d);
            chk(base[7] ? "R3 view after R5 write" : "R3 view after R4 block", d, view(exp_m));
          end
          set_ctx(1, pres, route); rd_reg(0, d);
          if (!sh)          chk("R2 pass-through", d, exp_m);
          else if (base[7]) chk("R5 accepted write", d, exp_m);
          else              chk("R4 blocked write", d, exp_m);
        end
      end
    end
  endtask

  task automatic irq_case(input string req, input logic [7:0] m, input logic [7:0] r,
                          input bit pv, input logic [7:0] p, input bit exp);
    set_ctx(1, 0, 0);
    wr_reg(0, m); wr_reg(1, r);
    @(negedge clk); pend_valid = pv; pend_prio = p;
    @(negedge clk); @(negedge clk);
    chk(req, {7'b0, irq_req}, {7'b0, exp});
  endtask

  task automatic t_irq();
    irq_case("R9 ns prio under 0x7F", 8'h7F, 8'hFF, 1, 8'h90, 0);
    irq_case("R9 prio 0x80 under 0x7F", 8'h7F, 8'hFF, 1, 8'h80, 0);
    irq_case("R8 below mask", 8'h7F, 8'hFF, 1, 8'h10, 1);
    irq_case("R8 equal mask", 8'h7F, 8'hFF, 1, 8'h7F, 0);
    irq_case("R8 equal running", 8'hFF, 8'h20, 1, 8'h20, 0);
    irq_case("R8 below running", 8'hFF, 8'h20, 1, 8'h1F, 1);
    irq_case("R8 not pending", 8'hFF, 8'hFF, 0, 8'h00, 0);
    irq_case("R8 mask zero", 8'h00, 8'hFF, 1, 8'h00, 0);
    irq_case("R8 ns half", 8'hC0, 8'hFF, 1, 8'hBF, 1);
    pend_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_examples();
    t_running_view();
    t_same_cycle();
    t_irq();
    t_exhaustive();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule